// File: doc/BRIEF.md
# Hashed Page Table Entry Encoder

This block turns a translation request into the two 64-bit words of a hashed page table entry, compares stored tag words against a probe, and scans a group of eight entries for a hit. A request carries a virtual address, a physical address, a page-size index and a segment-size code. One clock later the block returns a tag word, which holds the abbreviated virtual page number, the page and segment size markers and the entry flags. It also returns a real-page word, which holds the page-aligned physical address and the large-page size code. A request that names an unsupported page size or a reserved segment code returns an error and no entry.

A combinational compare port tells whether two tag words refer to the same virtual page. A stored word matches when every bit from 7 upward agrees with the probe, so the flag bits in positions 6:0 are ignored. The group scanner drives a slot index to external entry storage and reads back one tag word per cycle. It stops at the first valid matching slot, or reports a miss once all eight slots have been examined. Memory access, locking, replacement and reference/change tracking belong to the surrounding logic.

Top module: `hpte_encoder`

## Requirements
- R1: The tag word's virtual page field equals the virtual address shifted right by 23 with the selected size's clear mask removed, placed from bit 7 upward. The clear masks are 0 for index 0, 1 and 3, 0x1 for index 4, and 0x7FF for index 5.
- R2: Tag word bit 2 (large page) is 0 for page-size index 0 (4K) and 1 for every other supported index.
- R3: Tag word bits 63:62 carry the segment code (0 = 256M, 1 = 1T). Bit 0 (valid) is 1, bit 1 (secondary hash) copies the request's secondary input, bit 3 (lock) is 0 and bit 4 (bolted) copies the request's bolted input.
- R4: For index 0 the real-page word is the physical address with bits 63:62 and 11:0 cleared.
- R5: For the other supported indices, the real-page word is the physical address with its low page-shift bits cleared, ORed with the size code at bit 12. The shifts and codes are: index 1 (64K) 16 and 1, index 3 (1M) 20 and 2, index 4 (16M) 24 and 0, index 5 (16G) 34 and 3.
- R6: Page-size index 2, index 6 or 7, or segment code 2 or 3 raises the error output for one cycle with the entry-valid output at 0 and both entry words at 0.
- R7: Results appear in the cycle after the request. Without a request, the entry-valid and error outputs are 0.
- R8: The compare output is 1 exactly when the two words agree in bits 63:7. Bits 6:0 do not affect it.
- R9: A scan examines slot 0 in the first cycle after start and one further slot per cycle. It considers only entries with bit 0 set and reports the first matching slot. If the hit is at slot k, done pulses k+1 cycles after the start edge with hit = 1 and the slot number.
- R10: When no slot of the eight matches, done pulses 8 cycles after the start edge with hit = 0.
- R11: A start pulse while a scan is busy is ignored. The running scan keeps its tag and timing.
- R12: After reset, every output is 0 and the scanner is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_req | input | 1 | Encode request strobe |
| enc_va | input | 64 | Virtual address |
| enc_pa | input | 64 | Physical address, assumed page aligned |
| enc_psize | input | 3 | Page-size index |
| enc_seg | input | 2 | Segment-size code |
| enc_secondary | input | 1 | Secondary hash flag for the tag word |
| enc_bolted | input | 1 | Bolted flag for the tag word |
| ent_valid | output | 1 | Entry words are valid this cycle |
| ent_err | output | 1 | Request rejected this cycle |
| ent_tag_word | output | 64 | First (tag) word |
| ent_real_word | output | 64 | Second (real-page) word |
| cmp_stored | input | 64 | Stored tag word to compare |
| cmp_probe | input | 64 | Computed tag word to compare |
| cmp_hit | output | 1 | Compare result |
| scan_start | input | 1 | Start a group scan |
| scan_tag | input | 64 | Tag word to search for |
| scan_entry | input | 64 | Tag word of the slot selected by scan_slot_sel |
| scan_slot_sel | output | 3 | Slot being read |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| scan_hit | output | 1 | Last scan found a match |
| scan_slot | output | 3 | Matching slot of the last scan |

## Verification
A corrupted size-table entry shows up in the next cycle. It appears as a shifted virtual page field, a wrong large flag or a misplaced size code in the real-page word, and every page size is driven with address patterns that expose those bits. A scanner whose slot counter or tag register goes wrong reports the wrong slot or the wrong completion cycle. The bench therefore measures the exact cycle of the done pulse for hits at the first, a middle and the last slot and for a miss, with invalid and low-bit-noisy decoys placed ahead of the true hit.

// File: rtl/hpte_enc_pkg.sv
`timescale 1ns/1ps
// Package: field positions of the entry words and the per-size descriptor table.
// Assumes 64-bit entry words; index positions are fixed by the entry format.
package hpte_enc_pkg;
    localparam int WORD_W        = 64;
    localparam int VA_TAG_SHIFT  = 23;   // virtual address bits dropped before tag placement
    localparam int TAG_VPN_LSB   = 7;
    localparam int TAG_VALID_BIT = 0;
    localparam int TAG_SEC_BIT   = 1;
    localparam int TAG_LARGE_BIT = 2;
    localparam int TAG_LOCK_BIT  = 3;
    localparam int TAG_BOLT_BIT  = 4;
    localparam int TAG_SEG_LSB   = 62;
    localparam int REAL_CODE_LSB = 12;
    localparam logic [WORD_W-1:0] REAL_4K_MASK = 64'h3FFF_FFFF_FFFF_F000;
    localparam logic [WORD_W-1:0] TAG_CMP_MASK = 64'hFFFF_FFFF_FFFF_FF80;

    typedef struct packed {
        logic [5:0]        shift;     // 0 marks an unsupported size
        logic [3:0]        lp_code;   // size code placed in the real-page word
        logic [WORD_W-1:0] vpn_clr;   // bits removed from the shifted virtual address
    } size_desc_t;

    // Descriptor for one page-size index
    function automatic size_desc_t size_desc(input int idx);
        size_desc_t d;
        d = '0;
        case (idx)
            0: begin d.shift = 6'd12; d.lp_code = 4'd0; d.vpn_clr = 64'h0;   end
            1: begin d.shift = 6'd16; d.lp_code = 4'd1; d.vpn_clr = 64'h0;   end
            2: begin d.shift = 6'd0;  d.lp_code = 4'd0; d.vpn_clr = 64'h0;   end
            3: begin d.shift = 6'd20; d.lp_code = 4'd2; d.vpn_clr = 64'h0;   end
            4: begin d.shift = 6'd24; d.lp_code = 4'd0; d.vpn_clr = 64'h1;   end
            5: begin d.shift = 6'd34; d.lp_code = 4'd3; d.vpn_clr = 64'h7FF; end
            default: d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/hpte_size_table.sv
`timescale 1ns/1ps
// Size table: selects the descriptor for a page-size index.
// Assumes indices at or above NUM_SIZES are unsupported.
module hpte_size_table
    import hpte_enc_pkg::*;
#(
    parameter int NUM_SIZES = 6,
    parameter int PSIZE_W   = 3
) (
    input  logic [PSIZE_W-1:0] idx,
    output size_desc_t         desc,
    output logic               supported
);
    size_desc_t tbl [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_row
        assign tbl[g] = size_desc(g);
    end

    // Select the row whose index matches, zero if none
    always_comb begin
        desc = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (int'(idx) == i) desc = tbl[i];
        end
        supported = (desc.shift != 6'd0);
    end
endmodule

// File: rtl/hpte_tag_cmp.sv
`timescale 1ns/1ps
// Tag compare: two tag words match when bits 63:7 agree; flag bits are ignored.
module hpte_tag_cmp
    import hpte_enc_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic              match
);
    // Masked equality of the page-identifying bits
    always_comb begin
        match = (((word_a ^ word_b) & TAG_CMP_MASK) == '0);
        assert_self_match_R8: assert (!(word_a === word_b) || match);
    end
endmodule

// File: rtl/hpte_word_builder.sv
`timescale 1ns/1ps
// Word builder: forms the tag and real-page words, registered once.
// Assumes the physical address is aligned to the requested page size.
module hpte_word_builder
    import hpte_enc_pkg::*;
#(
    parameter int NUM_SIZES = 6,
    parameter int PSIZE_W   = 3,
    parameter int SEG_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [WORD_W-1:0]  va,
    input  logic [WORD_W-1:0]  pa,
    input  logic [PSIZE_W-1:0] psize,
    input  logic [SEG_W-1:0]   seg,
    input  logic               secondary,
    input  logic               bolted,
    output logic               out_valid,
    output logic               out_err,
    output logic [WORD_W-1:0]  tag_word,
    output logic [WORD_W-1:0]  real_word
);
    size_desc_t        desc;
    logic              size_ok;
    logic              seg_ok;
    logic              accept;
    logic [WORD_W-1:0] vpn;
    logic [WORD_W-1:0] tag_c;
    logic [WORD_W-1:0] real_c;

    hpte_size_table #(.NUM_SIZES(NUM_SIZES), .PSIZE_W(PSIZE_W)) size_i (
        .idx(psize), .desc(desc), .supported(size_ok)
    );

    // Codes 0 and 1 are the only defined segment sizes
    assign seg_ok = (seg < SEG_W'(2));
    assign accept = req && size_ok && seg_ok;

    // Tag word assembly
    always_comb begin
        vpn   = (va >> VA_TAG_SHIFT) & ~desc.vpn_clr;
        tag_c = vpn << TAG_VPN_LSB;
        tag_c[TAG_SEG_LSB +: SEG_W] = seg;
        tag_c[TAG_BOLT_BIT]  = bolted;
        tag_c[TAG_LOCK_BIT]  = 1'b0;
        tag_c[TAG_LARGE_BIT] = (psize != '0);
        tag_c[TAG_SEC_BIT]   = secondary;
        tag_c[TAG_VALID_BIT] = 1'b1;
    end

    // Real-page word assembly
    always_comb begin
        if (psize == '0)
            real_c = pa & REAL_4K_MASK;
        else
            real_c = (pa & ~((64'd1 << desc.shift) - 64'd1))
                   | (WORD_W'(desc.lp_code) << REAL_CODE_LSB);
    end

    // Output register: one-cycle result or error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            tag_word  <= '0;
            real_word <= '0;
        end else begin
            out_valid <= accept;
            out_err   <= req && !accept;
            tag_word  <= accept ? tag_c  : '0;
            real_word <= accept ? real_c : '0;
        end
    end

    assert_valid_xor_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));
    assert_reserved_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req && seg[1] |=> out_err && !out_valid && tag_word == '0 && real_word == '0);
    assert_small_page_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req && psize == '0 && !seg[1] |=> out_valid && !tag_word[TAG_LARGE_BIT]);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !out_valid && !out_err);
    assert_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tag_word[TAG_VALID_BIT] && !tag_word[TAG_LOCK_BIT]);
endmodule

// File: rtl/hpte_group_scan.sv
`timescale 1ns/1ps
// Group scanner: reads one slot per cycle from external storage and stops at
// the first valid slot whose tag matches. Assumes scan_entry reflects slot_sel
// in the same cycle.
module hpte_group_scan
    import hpte_enc_pkg::*;
#(
    parameter int GROUP_SIZE = 8,
    parameter int SLOT_W     = $clog2(GROUP_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tag,
    input  logic [WORD_W-1:0] entry,
    output logic [SLOT_W-1:0] slot_sel,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SIZE - 1);

    logic [WORD_W-1:0] tag_q;
    logic [SLOT_W-1:0] idx_q;
    logic              tag_match;
    logic              cand;

    hpte_tag_cmp cmp_i (.word_a(tag_q), .word_b(entry), .match(tag_match));

    assign cand     = busy && entry[TAG_VALID_BIT] && tag_match;
    assign slot_sel = idx_q;

    // Scan sequencer: start, advance, stop on hit or after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            idx_q    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            hit      <= 1'b0;
            hit_slot <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    tag_q    <= tag;
                    idx_q    <= '0;
                    busy     <= 1'b1;
                    hit      <= 1'b0;
                    hit_slot <= '0;
                end
            end else if (cand) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                hit      <= 1'b1;
                hit_slot <= idx_q;
            end else if (idx_q == LAST_SLOT) begin
                busy <= 1'b0;
                done <= 1'b1;
                hit  <= 1'b0;
            end else begin
                idx_q <= idx_q + SLOT_W'(1);
            end
        end
    end

    assert_done_follows_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);
    assert_first_match_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && entry[TAG_VALID_BIT] && tag_match |=> done && hit && hit_slot == $past(idx_q));
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tag_q));
    assert_miss_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cand && idx_q == LAST_SLOT |=> done && !hit);
endmodule

// File: rtl/hpte_encoder.sv
`timescale 1ns/1ps
// Top: hashed page table entry encoder with tag compare and group scan.
// Assumes external logic owns the entry storage and answers scan_slot_sel
// combinationally on scan_entry.
module hpte_encoder
    import hpte_enc_pkg::*;
#(
    parameter int NUM_SIZES  = 6,
    parameter int PSIZE_W    = 3,
    parameter int SEG_W      = 2,
    parameter int GROUP_SIZE = 8,
    parameter int SLOT_W     = $clog2(GROUP_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_req,
    input  logic [63:0]        enc_va,
    input  logic [63:0]        enc_pa,
    input  logic [PSIZE_W-1:0] enc_psize,
    input  logic [SEG_W-1:0]   enc_seg,
    input  logic               enc_secondary,
    input  logic               enc_bolted,
    output logic               ent_valid,
    output logic               ent_err,
    output logic [63:0]        ent_tag_word,
    output logic [63:0]        ent_real_word,
    input  logic [63:0]        cmp_stored,
    input  logic [63:0]        cmp_probe,
    output logic               cmp_hit,
    input  logic               scan_start,
    input  logic [63:0]        scan_tag,
    input  logic [63:0]        scan_entry,
    output logic [SLOT_W-1:0]  scan_slot_sel,
    output logic               scan_busy,
    output logic               scan_done,
    output logic               scan_hit,
    output logic [SLOT_W-1:0]  scan_slot
);
    hpte_word_builder #(.NUM_SIZES(NUM_SIZES), .PSIZE_W(PSIZE_W), .SEG_W(SEG_W)) build_i (
        .clk(clk), .rst_n(rst_n), .req(enc_req), .va(enc_va), .pa(enc_pa),
        .psize(enc_psize), .seg(enc_seg), .secondary(enc_secondary), .bolted(enc_bolted),
        .out_valid(ent_valid), .out_err(ent_err),
        .tag_word(ent_tag_word), .real_word(ent_real_word)
    );

    hpte_tag_cmp port_cmp_i (.word_a(cmp_stored), .word_b(cmp_probe), .match(cmp_hit));

    hpte_group_scan #(.GROUP_SIZE(GROUP_SIZE), .SLOT_W(SLOT_W)) scan_i (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .tag(scan_tag), .entry(scan_entry),
        .slot_sel(scan_slot_sel), .busy(scan_busy), .done(scan_done),
        .hit(scan_hit), .hit_slot(scan_slot)
    );
endmodule

// File: tb/hpte_encoder_tb_top.sv
`timescale 1ns/1ps
module hpte_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enc_req;
    logic [63:0] enc_va, enc_pa;
    logic [2:0]  enc_psize;
    logic [1:0]  enc_seg;
    logic        enc_secondary, enc_bolted;
    logic        ent_valid, ent_err;
    logic [63:0] ent_tag_word, ent_real_word;
    logic [63:0] cmp_stored, cmp_probe;
    logic        cmp_hit;
    logic        scan_start;
    logic [63:0] scan_tag;
    logic [63:0] scan_entry;
    logic [2:0]  scan_slot_sel;
    logic        scan_busy, scan_done, scan_hit;
    logic [2:0]  scan_slot;
    logic [63:0] mem [8];

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    assign scan_entry = mem[scan_slot_sel];

    hpte_encoder dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            finish_run();
        end
    end

    // Reference model from the requirements (R1, R5)
    function automatic int ref_shift(input int ps);
        case (ps) 0: return 12; 1: return 16; 3: return 20; 4: return 24; 5: return 34;
            default: return 0; endcase
    endfunction
    function automatic logic [63:0] ref_code(input int ps);
        case (ps) 1: return 64'd1; 3: return 64'd2; 5: return 64'd3; default: return 64'd0; endcase
    endfunction
    function automatic logic [63:0] ref_clr(input int ps);
        case (ps) 4: return 64'h1; 5: return 64'h7FF; default: return 64'h0; endcase
    endfunction
    function automatic bit ref_err(input int ps, input int sg);
        return (ref_shift(ps) == 0) || (sg > 1);
    endfunction
    function automatic logic [63:0] ref_tag(input logic [63:0] va, input int ps, input int sg,
                                            input bit sec, input bit bolt);
        logic [63:0] w;
        w = ((va >> 23) & ~ref_clr(ps)) << 7;
        w = w | (64'(sg) << 62) | (64'(bolt) << 4) | (64'(ps != 0) << 2) | (64'(sec) << 1) | 64'd1;
        return w;
    endfunction
    function automatic logic [63:0] ref_real(input logic [63:0] pa, input int ps);
        if (ps == 0) return pa & 64'h3FFF_FFFF_FFFF_F000;
        return (pa & ~((64'd1 << ref_shift(ps)) - 64'd1)) | (ref_code(ps) << 12);
    endfunction

    localparam int NV = 10;
    localparam logic [63:0] V_VA [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0000_7FFF_FFFF_FFFF,
        64'h0000_0000_0180_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444,
        64'h5555_AAAA_5555_AAAA, 64'h0F0F_0F0F_0F0F_0F0F, 64'h8000_0000_0080_0000,
        64'h0000_0FFF_FF80_0000 };
    localparam logic [63:0] V_PA [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00AB_CDEF_1234, 64'h0000_0012_3456_7890,
        64'h0000_0000_01FF_F000, 64'h0000_0007_FFFF_FFFF, 64'h0000_0000_0001_0000,
        64'h0000_0000_0010_0000, 64'h0000_0000_0000_1000, 64'h0000_0000_0002_0000,
        64'h0000_0000_0000_2000 };
    localparam int V_PS  [NV] = '{0, 1, 3, 4, 5, 2, 6, 0, 1, 7};
    localparam int V_SG  [NV] = '{0, 1, 0, 1, 0, 0, 1, 2, 3, 0};
    localparam bit V_SEC [NV] = '{0, 1, 0, 1, 1, 0, 0, 0, 1, 0};
    localparam bit V_BLT [NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 0, 0};

    // Run one scan; returns the negedge count at which done was seen
    task automatic run_scan(input logic [63:0] tag, output int cnt);
        @(negedge clk);
        scan_tag = tag; scan_start = 1'b1;
        @(posedge clk); #1;
        scan_start = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cnt++;
            if (scan_done) break;
        end
    endtask

    localparam logic [63:0] T = 64'h4000_1234_5678_9A80;

    task automatic fill_miss();
        for (int s = 0; s < 8; s++) mem[s] = (T ^ (64'h80 << s)) | 64'd1;
    endtask

    initial begin
        int cnt;
        rst_n = 1'b0; enc_req = 0; enc_va = '0; enc_pa = '0; enc_psize = '0; enc_seg = '0;
        enc_secondary = 0; enc_bolted = 0; cmp_stored = '0; cmp_probe = '0;
        scan_start = 0; scan_tag = '0;
        for (int s = 0; s < 8; s++) mem[s] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 valid", 64'(ent_valid), 64'd0);
        chk("R12 err", 64'(ent_err), 64'd0);
        chk("R12 tag", ent_tag_word, 64'd0);
        chk("R12 busy/done/hit", {61'd0, scan_busy, scan_done, scan_hit}, 64'd0);
        chk("R12 slot", 64'(scan_slot), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Encoder vector table (R1..R7)
        for (int v = 0; v < NV; v++) begin
            enc_req = 1; enc_va = V_VA[v]; enc_pa = V_PA[v]; enc_psize = 3'(V_PS[v]);
            enc_seg = 2'(V_SG[v]); enc_secondary = V_SEC[v]; enc_bolted = V_BLT[v];
            @(negedge clk);
            enc_req = 0;
            if (ref_err(V_PS[v], V_SG[v])) begin
                chk("R6 err", 64'(ent_err), 64'd1);
                chk("R6 no valid", 64'(ent_valid), 64'd0);
                chk("R6 words zero", ent_tag_word | ent_real_word, 64'd0);
            end else begin
                chk("R7 valid", 64'(ent_valid), 64'd1);
                chk("R1 R2 R3 tag word", ent_tag_word,
                    ref_tag(V_VA[v], V_PS[v], V_SG[v], V_SEC[v], V_BLT[v]));
                chk(V_PS[v] == 0 ? "R4 real word" : "R5 real word", ent_real_word,
                    ref_real(V_PA[v], V_PS[v]));
            end
            @(negedge clk);
            chk("R7 idle after request", {62'd0, ent_valid, ent_err}, 64'd0);
        end
        // R5 worked value for 16G: low 34 bits cleared, code 3 at bit 12
        chk("R5 16G constant", ref_real(64'h0000_0007_FFFF_FFFF, 5), 64'h0000_0004_0000_3000);

        // R8 compare port
        cmp_stored = T | 64'h7F; cmp_probe = T; #1;
        chk("R8 low bits ignored", 64'(cmp_hit), 64'd1);
        cmp_stored = T ^ 64'h80; #1;
        chk("R8 bit7 differs", 64'(cmp_hit), 64'd0);
        cmp_stored = T ^ 64'h8000_0000_0000_0000; #1;
        chk("R8 bit63 differs", 64'(cmp_hit), 64'd0);

        // R9: invalid match at 2, noisy valid match at 5, another at 6
        fill_miss();
        mem[2] = T; mem[5] = T | 64'h7F; mem[6] = T | 64'd1;
        run_scan(T | 64'h55, cnt);
        chk("R9 hit", 64'(scan_hit), 64'd1);
        chk("R9 first valid slot", 64'(scan_slot), 64'd5);
        chk("R9 done timing slot 5", 64'(cnt), 64'd7);
        // R9: hit at slot 0 and slot 7
        fill_miss(); mem[0] = T | 64'd1;
        run_scan(T, cnt);
        chk("R9 slot0", {56'd0, 3'(scan_slot), 3'd0, 1'b0, scan_hit}, {56'd0, 3'd0, 3'd0, 1'b0, 1'b1});
        chk("R9 done timing slot 0", 64'(cnt), 64'd2);
        fill_miss(); mem[7] = T | 64'd1;
        run_scan(T, cnt);
        chk("R9 slot7", 64'(scan_slot), 64'd7);
        chk("R9 done timing slot 7", 64'(cnt), 64'd9);
        // R10: miss
        fill_miss();
        run_scan(T, cnt);
        chk("R10 miss", 64'(scan_hit), 64'd0);
        chk("R10 done timing", 64'(cnt), 64'd9);
        chk("R10 idle after", 64'(scan_busy), 64'd0);

        // R11: start while busy is ignored
        fill_miss(); mem[0] = (T ^ 64'h1000) | 64'd1;
        @(negedge clk);
        scan_tag = T; scan_start = 1;
        @(negedge clk);
        scan_tag = T ^ 64'h1000;  // would hit slot 0 if accepted
        @(negedge clk);
        scan_start = 0;
        cnt = 2;
        for (int i = 0; i < 20; i++) begin
            if (scan_done) break;
            @(negedge clk);
            cnt++;
        end
        chk("R11 restart ignored hit", 64'(scan_hit), 64'd0);
        chk("R11 restart ignored timing", 64'(cnt), 64'd9);

        finish_run();
    end
endmodule